// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is a synthesizable I2C target that behaves like a byte-wide serial EEPROM. SCL and SDA are brought into the system clock domain through a synchronizer. Start and stop conditions and SCL edges are detected there, and a single state machine runs the protocol. SDA is returned as a drive-low enable, so it can be combined open-drain with the host. The array holds `2**ADDR_W` bytes. With `ADDR_W` set to 13 it is the full 8K x 8 part, and the protected window is 0x1800 to 0x1FFF. The default is smaller to keep elaboration light.

Writes do not go straight into the array. Data bytes are collected in a page buffer. A stop condition commits them, but only if the write-protect level at that stop allows it. A programming timer then runs for `WRITE_CYCLES` clocks, and the buffer is copied into the array one byte per clock. While the timer runs, the target refuses its control byte, so a host can poll for completion.

The states of the machine are as follows:

- `ST_IDLE` is the idle state.
- `ST_CTRL` shifts in the control byte. It goes to `ST_CTRL_ACK` on a match while not busy, and to `ST_SKIP` otherwise.
- After the control acknowledge, a write goes to `ST_AHI` and a read goes to `ST_RDATA`.
- The write path is `ST_AHI` → `ST_AHI_ACK` → `ST_ALO` → `ST_ALO_ACK` → `ST_WDATA`. From there, `ST_WDATA` and `ST_WDATA_ACK` repeat for each byte.
- The read path is `ST_RDATA` → `ST_RDATA_ACK`. On a host acknowledge it goes back to `ST_RDATA`. On a host not-acknowledge it goes to `ST_SKIP`.
- A stop from any state returns to `ST_IDLE`.
- A start from any state enters `ST_CTRL`.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset the SDA drive enable is low and the target is idle.
- R2: A control byte is accepted only if its upper nibble is 4'b1010 and bits 3:1 equal `sel_i`. Bit 0 gives the direction, with 1 meaning read. A mismatched control byte is not acknowledged, and nothing further is acknowledged until the next start.
- R3: Each accepted byte is acknowledged by pulling SDA low for the ninth clock. The drive enable only rises while SCL is low.
- R4: A write carries two address bytes after the control byte, high byte first. Only the low `ADDR_W` bits of the 16 address bits are used.
- R5: A byte write (control, address, one data byte, stop) changes only that byte. Its programming cycle starts at the stop.
- R6: In a page write, only the low 5 pointer bits advance. Bytes past the end of a 32-byte page wrap to its start, and later bytes overwrite earlier ones.
- R7: While the programming cycle runs, the control byte is not acknowledged. After the cycle ends, it is acknowledged again.
- R8: `wp_i` is sampled at the stop. If it is high and the page lies in the top quarter of the array, nothing is written and no programming cycle starts. Pages below that quarter are always written.
- R9: Buffered data is dropped if a start arrives before a stop. A write with no data bytes only sets the pointer. Neither case starts a programming cycle.
- R10: Reads shift data out MSB first. After each byte, the pointer advances over the whole array and wraps from the last address to 0. A random read is an address write followed by a repeated start. A read without an address continues from the pointer.
- R11: After a host not-acknowledge, the target releases SDA and drives nothing until the next start or stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Resolved serial data line |
| wp_i | input | 1 | Write-protect level for the top quarter |
| sel_i | input | 3 | Chip-select strap compared with the control byte |
| sda_drive_o | output | 1 | When high, pull SDA low |

## Verification
Some properties are checked on every cycle:

- The drive enable only rises while the synchronized SCL is low.
- The drive enable is only high in an acknowledge or read-data state.
- No control byte is acknowledged while the programming timer is busy.
- A programming cycle starts only after a stop.
- No byte is written into the top quarter of the array after a stop that saw write-protect high.

Other behaviour can only be shown by the bench's transactions:

- page wrap-around
- loss of buffered data on a repeated start
- pointer continuity across current-address reads
- the wrap from the last address to the first
- the effect of write-protect being sampled at the stop rather than during the data bytes

// File: rtl/eep_pkg.sv
`timescale 1ns/1ps
package eep_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_SKIP
    } eep_state_e;

    localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/eep_bus_sense.sv
`timescale 1ns/1ps
module eep_bus_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    assign scl_s     = scl_sh[SYNC_STAGES-1];
    assign sda_s     = sda_sh[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    // data edges only count while the clock has been high for two samples
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eep_prog_timer.sv
`timescale 1ns/1ps
module eep_prog_timer #(
    parameter int CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain <= '0;
        else if (start)
            remain <= CW'(CYCLES);
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/eep_page_store.sv
`timescale 1ns/1ps
module eep_page_store #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              clr,
    input  logic              commit,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              pending,
    output logic              copying,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_wa
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int PG_W       = ADDR_W - PAGE_W;

    logic [7:0]            mem  [DEPTH];
    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] valid;
    logic [PG_W-1:0]       page;
    logic [PAGE_W-1:0]     idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid   <= '0;
            page    <= '0;
            copying <= 1'b0;
            idx     <= '0;
        end else if (copying) begin
            idx <= idx + 1'b1;
            if (idx == '1) begin
                copying <= 1'b0;
                valid   <= '0;
            end
        end else if (commit) begin
            copying <= 1'b1;
            idx     <= '0;
        end else if (clr) begin
            valid <= '0;
        end else if (wr_stb) begin
            valid[wr_addr[PAGE_W-1:0]] <= 1'b1;
            page                       <= wr_addr[ADDR_W-1:PAGE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (wr_stb && !copying)
            pbuf[wr_addr[PAGE_W-1:0]] <= wr_data;
    end

    assign mem_we = copying & valid[idx];
    assign mem_wa = {page, idx};

    always_ff @(posedge clk) begin
        if (mem_we)
            mem[mem_wa] <= pbuf[idx];
    end

    assign rd_data = mem[rd_addr];
    assign pending = |valid;
endmodule

// File: rtl/i2c_eeprom_target.sv
`timescale 1ns/1ps
module i2c_eeprom_target #(
    parameter int ADDR_W       = 11,
    parameter int PAGE_W       = 5,
    parameter int WRITE_CYCLES = 50000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       wp_i,
    input  logic [2:0] sel_i,
    output logic       sda_drive_o
);
    import eep_pkg::*;

    localparam int HI_KEEP = (ADDR_W > 8) ? ADDR_W - 8 : 1;

    eep_state_e state, nxt;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic busy, pending, copying, mem_we;
    logic [ADDR_W-1:0] mem_wa, ptr, addr_full;
    logic [7:0] shreg, rd_byte, rd_data;
    logic [HI_KEEP-1:0] addr_hi;
    logic [3:0] cnt;
    logic dir_rd, host_ack, drive;
    logic byte_done, ctrl_ok, in_upper, commit_go, buf_clr, wr_stb;

    eep_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    eep_prog_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(commit_go), .busy(busy)
    );

    eep_page_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_stb(wr_stb), .wr_addr(ptr), .wr_data(shreg),
        .clr(buf_clr), .commit(commit_go),
        .rd_addr(ptr), .rd_data(rd_data),
        .pending(pending), .copying(copying),
        .mem_we(mem_we), .mem_wa(mem_wa)
    );

    generate
        if (ADDR_W > 8) begin : g_wide
            assign addr_full = {addr_hi, shreg};
        end else begin : g_narrow
            assign addr_full = shreg[ADDR_W-1:0];
        end
    endgenerate

    assign byte_done = scl_fall && (cnt == 4'd8);
    assign ctrl_ok   = (shreg[7:4] == DEV_CODE) && (shreg[3:1] == sel_i) && !busy;
    assign in_upper  = (ptr[ADDR_W-1 -: 2] == 2'b11);
    assign commit_go = stop_det && pending && !copying && !(wp_i && in_upper);
    assign buf_clr   = start_det || (stop_det && !commit_go);
    assign wr_stb    = (state == ST_WDATA) && byte_done;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        if (stop_det)
            nxt = ST_IDLE;
        else if (start_det)
            nxt = ST_CTRL;
        else begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_CTRL:      if (byte_done) nxt = ctrl_ok ? ST_CTRL_ACK : ST_SKIP;
                ST_CTRL_ACK:  if (scl_fall)  nxt = dir_rd ? ST_RDATA : ST_AHI;
                ST_AHI:       if (byte_done) nxt = ST_AHI_ACK;
                ST_AHI_ACK:   if (scl_fall)  nxt = ST_ALO;
                ST_ALO:       if (byte_done) nxt = ST_ALO_ACK;
                ST_ALO_ACK:   if (scl_fall)  nxt = ST_WDATA;
                ST_WDATA:     if (byte_done) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall)  nxt = ST_WDATA;
                ST_RDATA:     if (byte_done) nxt = ST_RDATA_ACK;
                ST_RDATA_ACK: if (scl_fall)  nxt = host_ack ? ST_RDATA : ST_SKIP;
                ST_SKIP:      nxt = ST_SKIP;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            shreg    <= '0;
            addr_hi  <= '0;
            ptr      <= '0;
            rd_byte  <= '0;
            dir_rd   <= 1'b0;
            host_ack <= 1'b0;
            drive    <= 1'b0;
        end else if (stop_det || start_det) begin
            cnt   <= '0;
            drive <= 1'b0;
        end else begin
            case (state)
                ST_CTRL, ST_AHI, ST_ALO, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg <= {shreg[6:0], sda_s};
                        cnt   <= cnt + 4'd1;
                    end else if (byte_done) begin
                        cnt <= '0;
                        if (state == ST_CTRL) begin
                            drive  <= ctrl_ok;
                            dir_rd <= shreg[0];
                        end else begin
                            drive <= 1'b1;
                        end
                        if (state == ST_AHI)
                            addr_hi <= shreg[HI_KEEP-1:0];
                        if (state == ST_ALO)
                            ptr <= addr_full;
                        if (state == ST_WDATA)
                            ptr <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
                    end
                end
                ST_CTRL_ACK: begin
                    if (scl_fall) begin
                        if (dir_rd) begin
                            rd_byte <= rd_data;
                            drive   <= ~rd_data[7];
                            ptr     <= ptr + 1'b1;
                        end else begin
                            drive <= 1'b0;
                        end
                    end
                end
                ST_AHI_ACK, ST_ALO_ACK, ST_WDATA_ACK: begin
                    if (scl_fall)
                        drive <= 1'b0;
                end
                ST_RDATA: begin
                    if (scl_rise)
                        cnt <= cnt + 4'd1;
                    else if (scl_fall) begin
                        if (cnt == 4'd8) begin
                            drive <= 1'b0;
                            cnt   <= '0;
                        end else begin
                            drive <= ~rd_byte[3'd7 - cnt[2:0]];
                        end
                    end
                end
                ST_RDATA_ACK: begin
                    if (scl_rise)
                        host_ack <= ~sda_s;
                    else if (scl_fall && host_ack) begin
                        rd_byte <= rd_data;
                        drive   <= ~rd_data[7];
                        ptr     <= ptr + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_drive_o = drive;
endmodule

// File: rtl/eep_target_chk.sv
`timescale 1ns/1ps
module eep_target_chk
    import eep_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              stop_det,
    input logic              wp_i,
    input logic              sda_drive_o,
    input eep_state_e        state,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_wa
);
    logic wp_at_stop;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wp_at_stop <= 1'b0;
        else if (stop_det && !busy)
            wp_at_stop <= wp_i;
    end

    // R3
    drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_o) |-> !scl_s);

    // R3
    drive_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_drive_o |-> (state == ST_CTRL_ACK || state == ST_AHI_ACK ||
                         state == ST_ALO_ACK || state == ST_WDATA_ACK ||
                         state == ST_RDATA));

    // R7
    busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CTRL_ACK && sda_drive_o) |-> !busy);

    // R5
    cycle_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_det));

    // R8
    wp_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_wa[ADDR_W-1 -: 2] == 2'b11) |-> !wp_at_stop);
endmodule

bind i2c_eeprom_target eep_target_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det),
    .wp_i(wp_i), .sda_drive_o(sda_drive_o), .state(state), .busy(busy),
    .mem_we(mem_we), .mem_wa(mem_wa)
);

// File: tb/i2c_eeprom_target_test.sv
`timescale 1ns/1ps
module i2c_eeprom_target_test;
    localparam int AW = 8;
    localparam int PW = 5;
    localparam int WC = 400;
    localparam int HP = 8;
    localparam logic [3:0] DEV = 4'b1010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic host_low = 1'b0;
    logic wp = 1'b0;
    logic [2:0] sel = 3'b101;
    logic [7:0] hi_byte = 8'h00;
    wire drv;
    wire sda = ~(host_low | drv);

    int checks = 0;
    int fails = 0;
    logic [7:0] model [256];
    logic [7:0] wbuf [64];

    always #2.5 clk = ~clk;

    i2c_eeprom_target #(.ADDR_W(AW), .PAGE_W(PW), .WRITE_CYCLES(WC)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .wp_i(wp), .sel_i(sel), .sda_drive_o(drv)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bstart;
        scl = 1'b0; tick(2); host_low = 1'b0; tick(HP);
        scl = 1'b1; tick(HP); host_low = 1'b1; tick(HP);
    endtask

    task automatic bstop;
        scl = 1'b0; tick(2); host_low = 1'b1; tick(HP);
        scl = 1'b1; tick(HP); host_low = 1'b0; tick(HP);
    endtask

    task automatic send_bit(input logic b);
        scl = 1'b0; tick(2); host_low = ~b; tick(HP - 2);
        scl = 1'b1; tick(HP);
    endtask

    task automatic recv_bit(output logic b);
        scl = 1'b0; tick(2); host_low = 1'b0; tick(HP - 2);
        scl = 1'b1; tick(HP / 2); b = sda; tick(HP / 2);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(x);
        ack = ~x;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic give_ack);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(x);
            v[i] = x;
        end
        send_bit(~give_ack);
    endtask

    task automatic wr(input logic [7:0] a, input int n, input logic wp_stop, output logic allack);
        logic k;
        allack = 1'b1;
        bstart;
        send_byte({DEV, sel, 1'b0}, k); allack &= k;
        send_byte(hi_byte, k);          allack &= k;
        send_byte(a, k);                allack &= k;
        for (int j = 0; j < n; j++) begin
            send_byte(wbuf[j], k);
            allack &= k;
        end
        wp = wp_stop;
        bstop;
    endtask

    task automatic model_write(input logic [7:0] a, input int n);
        for (int j = 0; j < n; j++)
            model[{a[7:5], 5'(a[4:0] + 5'(j))}] = wbuf[j];
    endtask

    task automatic poll_ready(output int polls);
        logic k;
        polls = 0;
        for (int g = 0; g < 40; g++) begin
            bstart;
            send_byte({DEV, sel, 1'b0}, k);
            bstop;
            if (k) break;
            polls++;
        end
    endtask

    task automatic rd_seq(input logic [7:0] a, input int n, input string req);
        logic k;
        logic [7:0] v;
        bstart;
        send_byte({DEV, sel, 1'b0}, k);
        send_byte(hi_byte, k);
        send_byte(a, k);
        bstart;
        send_byte({DEV, sel, 1'b1}, k);
        check(req, k, 1'b1);
        for (int j = 0; j < n; j++) begin
            recv_byte(v, j != n - 1);
            check(req, v, model[8'(a + 8'(j))]);
        end
        bstop;
    endtask

    task automatic cur_rd(input logic [7:0] a, input string req);
        logic k;
        logic [7:0] v;
        bstart;
        send_byte({DEV, sel, 1'b1}, k);
        recv_byte(v, 1'b0);
        bstop;
        check(req, v, model[a]);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic k, allack;
        logic [7:0] v;
        int polls;

        // R1 reset state
        tick(10);
        check("R1", drv, 1'b0);
        rst_n = 1'b1;
        tick(6);
        check("R1", drv, 1'b0);

        // R2 wrong select, wrong code, ignored afterwards, then a match
        bstart; send_byte({DEV, 3'b010, 1'b0}, k); check("R2", k, 1'b0);
        send_byte(8'h00, k); check("R2", k, 1'b0); bstop;
        bstart; send_byte({4'b1011, sel, 1'b0}, k); check("R2", k, 1'b0); bstop;
        bstart; send_byte({DEV, sel, 1'b0}, k); check("R2", k, 1'b1); bstop;

        // R6 R5 full-array sweep in 32-byte pages
        for (int p = 0; p < 8; p++) begin
            for (int j = 0; j < 32; j++) wbuf[j] = 8'((p * 32 + j) * 37 + 92);
            wr(8'(p * 32), 32, 1'b0, allack);
            check("R3", allack, 1'b1);
            model_write(8'(p * 32), 32);
            poll_ready(polls);
            check("R7", polls > 0, 1'b1);
        end
        // R10 sequential read of the whole array, then the pointer has wrapped
        rd_seq(8'h00, 256, "R10");
        cur_rd(8'h00, "R10");
        rd_seq(8'hFE, 4, "R10");

        // R5 byte write, R7 busy right after
        wbuf[0] = 8'hA5;
        wr(8'h10, 1, 1'b0, allack);
        model_write(8'h10, 1);
        bstart; send_byte({DEV, sel, 1'b0}, k); bstop;
        check("R7", k, 1'b0);
        poll_ready(polls);
        rd_seq(8'h0F, 3, "R5");

        // R6 page wrap with overwrite
        for (int j = 0; j < 35; j++) wbuf[j] = 8'hC0 ^ 8'(j);
        wr(8'h45, 35, 1'b0, allack);
        model_write(8'h45, 35);
        poll_ready(polls);
        check("R6", polls > 0, 1'b1);
        rd_seq(8'h3F, 34, "R6");

        // R8 protection
        wp = 1'b1;
        wbuf[0] = 8'h11;
        wr(8'hC3, 1, 1'b1, allack);
        poll_ready(polls);
        check("R8", polls, 0);
        rd_seq(8'hC3, 1, "R8");
        wbuf[0] = 8'h22;
        wr(8'hBF, 1, 1'b1, allack);
        model_write(8'hBF, 1);
        poll_ready(polls);
        check("R8", polls > 0, 1'b1);
        rd_seq(8'hBF, 1, "R8");
        wp = 1'b0;
        wbuf[0] = 8'h33;
        wr(8'hE0, 1, 1'b1, allack);
        poll_ready(polls);
        check("R8", polls, 0);
        rd_seq(8'hE0, 1, "R8");
        wp = 1'b1;
        wbuf[0] = 8'h44; wbuf[1] = 8'h55;
        wr(8'hF0, 2, 1'b0, allack);
        model_write(8'hF0, 2);
        poll_ready(polls);
        check("R8", polls > 0, 1'b1);
        rd_seq(8'hF0, 2, "R8");
        wp = 1'b0;

        // R9 repeated start drops buffered data
        bstart;
        send_byte({DEV, sel, 1'b0}, k);
        send_byte(8'h00, k);
        send_byte(8'h30, k);
        send_byte(8'h77, k);
        bstart;
        send_byte({DEV, sel, 1'b1}, k);
        recv_byte(v, 1'b0);
        bstop;
        check("R9", v, model[8'h31]);
        poll_ready(polls);
        check("R9", polls, 0);
        rd_seq(8'h30, 1, "R9");

        // R9 R4 address-only write with a non-zero high byte
        hi_byte = 8'hA7;
        wr(8'h5A, 0, 1'b0, allack);
        poll_ready(polls);
        check("R9", polls, 0);
        cur_rd(8'h5A, "R4");
        rd_seq(8'h20, 2, "R4");
        hi_byte = 8'h00;
        cur_rd(8'h22, "R10");

        // R11 after a not-acknowledge the target stays off the bus
        bstart;
        send_byte({DEV, sel, 1'b1}, k);
        recv_byte(v, 1'b0);
        recv_byte(v, 1'b0);
        check("R11", v, 8'hFF);
        bstop;
        tick(4);
        check("R11", drv, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule